// File: doc/BRIEF.md
# Floppy Head Stepping Controller

This block moves the read/write head of a floppy drive. A host writes an 8-bit command byte. The upper nibble selects one of five head-positioning operations, or a force-interrupt. The low two bits choose the time between step pulses. While a command runs, the block issues step pulses of fixed width on `step_o` and sets the direction line `dirc_o`. It also keeps an 8-bit track register in step with every pulse it sends.

The drive reports four status lines: ready, track-zero, index and write-protect. Each passes through a two-flip-flop synchroniser. At the end of every command, and on a force-interrupt issued while idle, the block copies the synchronised values into a status byte. The status byte also carries a live busy bit and a restore-failure bit. A write-precompensation enable is derived from the track register, so the write path knows when the head is over the inner tracks.

Timing is counted from a microsecond tick, which a prescaler derives from the system clock. The prescaler restarts at the start of every pulse, so pulse widths and spacings are whole numbers of microseconds.

Top module: `fdc_head_stepper`

## Requirements
- R1: A command byte is accepted only while idle, and only with one of these exact shapes. Restore is `0000_00rr`, seek is `0001_00rr`, step is `0010_00rr`, step-in is `0100_00rr` and step-out is `0110_00rr`, where `rr` is the rate code. Force-interrupt is exactly `8'hD0` and is taken at any time. Any other byte, and any head command written while busy, has no effect.
- R2: Each step pulse on `step_o` is high for exactly 2 µs, which is 2·CLK_PER_US clock cycles.
- R3: Within one command, the start of one pulse to the start of the next lasts at least the rate interval and at most two clock cycles more. The rate codes 0, 1, 2 and 3 give 6, 12, 20 and 30 ms, where 1 ms is US_PER_MS microsecond ticks.
- R4: A pulse issued with `dirc_o`=1 (away from track 0) adds one to the track register. A pulse issued with `dirc_o`=0 (toward track 0) subtracts one. Step-in drives `dirc_o`=1 and step-out drives 0. Step keeps the previous direction, which is 0 after reset.
- R5: `precomp_en_o` is high exactly when the track register is greater than 43.
- R6: Restore steps with `dirc_o`=0 until the synchronised track-zero input is high, then clears the track register to 0. If 255 pulses have gone out without reaching track zero, it stops and sets status bit 3. Status bit 3 is cleared when the next head command is accepted.
- R7: Seek compares the track register with the data register, which is written through `data_we`/`data_in`. It steps toward the data value until the two are equal. If they are already equal, no pulse is issued.
- R8: `busy_o` and status bit 0 are high from the cycle after a command is accepted until it ends. After reset, all outputs are 0.
- R9: A force-interrupt written while busy ends the command at the next pulse boundary. A pulse already high completes its full width, and no further pulse follows.
- R10: Status bits 1, 2, 4 and 5 hold the index, track-zero, write-protect and ready inputs. They are sampled when a command ends or when a force-interrupt is taken while idle, and they hold between those events. Bits 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte |
| data_we | input | 1 | Data (seek target) register write strobe |
| data_in | input | 8 | Seek target value |
| drv_ready | input | 1 | Drive ready status line |
| drv_trk0 | input | 1 | Drive track-zero status line |
| drv_index | input | 1 | Drive index pulse line |
| drv_wprot | input | 1 | Drive write-protect line |
| step_o | output | 1 | Step pulse to the drive |
| dirc_o | output | 1 | Step direction, 1 = away from track 0 |
| track_o | output | 8 | Track register |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Command in progress |
| precomp_en_o | output | 1 | Write-precompensation enable |

## Verification
Single-pulse commands are issued in both directions, and a plain step is sent after each of them. This separates a step that keeps the previous direction from one that is fixed. Seeks are run upward at three rate codes, downward, and onto the current track. Together they show whether the rate decoding is right, whether the sign of the difference picks the direction, and whether a seek with nothing to do issues a pulse.

Restore is tried two ways. In one, track-zero rises part way through. In the other, it never rises, which separates a clean home from the 255-pulse give-up. A force-interrupt is written in the middle of a pulse, which shows whether the pulse is cut or allowed to finish. Finally, the status inputs are changed while idle, which shows whether the status byte holds its snapshot or follows the inputs.

// File: rtl/fdc_step_pkg.sv
package fdc_step_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_PULSE,
    ST_WAIT
  } step_state_e;

  typedef enum logic [2:0] {
    OP_RESTORE,
    OP_SEEK,
    OP_STEP,
    OP_STEP_IN,
    OP_STEP_OUT
  } head_op_e;

  localparam logic [3:0] CODE_RESTORE  = 4'h0;
  localparam logic [3:0] CODE_SEEK     = 4'h1;
  localparam logic [3:0] CODE_STEP     = 4'h2;
  localparam logic [3:0] CODE_STEP_IN  = 4'h4;
  localparam logic [3:0] CODE_STEP_OUT = 4'h6;
  localparam logic [7:0] CODE_FORCE    = 8'hD0;

  localparam int PULSE_US = 2;
  localparam int SLOWEST_MS = 30;

  function automatic int rate_ms(input logic [1:0] code);
    case (code)
      2'd0:    rate_ms = 6;
      2'd1:    rate_ms = 12;
      2'd2:    rate_ms = 20;
      default: rate_ms = 30;
    endcase
  endfunction

endpackage

// File: rtl/fdc_sync2.sv
module fdc_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        sync_q <= meta_q;
      end
    end
    assign sync_o[b] = sync_q;
  end

endmodule

// File: rtl/fdc_us_timer.sv
module fdc_us_timer #(
  parameter int CLK_PER_US = 125,
  parameter int MAX_COUNT  = 30000,
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1,
  localparam int UW = $clog2(MAX_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [UW-1:0] us_cnt
);

  logic [PW-1:0] pre_q, pre_d;
  logic [UW-1:0] us_q, us_d;
  logic          tick;

  assign tick = (pre_q == PW'(CLK_PER_US - 1));

  always_comb begin
    pre_d = pre_q;
    us_d  = us_q;
    if (clear) begin
      pre_d = '0;
      us_d  = '0;
    end else begin
      pre_d = tick ? '0 : pre_q + PW'(1);
      if (tick && us_q != UW'(MAX_COUNT)) us_d = us_q + UW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else begin
      pre_q <= pre_d;
      us_q  <= us_d;
    end
  end

  assign us_cnt = us_q;

endmodule

// File: rtl/fdc_step_ctrl.sv
module fdc_step_ctrl
  import fdc_step_pkg::*;
#(
  parameter int CLK_PER_US    = 125,
  parameter int US_PER_MS     = 1000,
  parameter int RESTORE_LIMIT = 255,
  parameter int TRK_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_data,
  input  logic [TRK_W-1:0] seek_target,
  input  logic             trk0_s,
  output logic             step_o,
  output logic             dirc_o,
  output logic [TRK_W-1:0] track_o,
  output logic             busy_o,
  output logic             err_o,
  output logic             capture_o
);

  localparam int MAX_US = SLOWEST_MS * US_PER_MS;
  localparam int UW     = $clog2(MAX_US + 1);
  localparam int CW     = $clog2(RESTORE_LIMIT + 1);

  step_state_e      state_q, state_d;
  head_op_e         op_q, op_d, dec_op;
  logic [1:0]       rate_q, rate_d;
  logic [TRK_W-1:0] track_q, track_d;
  logic             dirc_q, dirc_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             abort_q, abort_d;
  logic             err_q, err_d;
  logic [UW-1:0]    us_cnt, gap_us;
  logic             tmr_clear, fin, issue, issue_dir, dec_ok, head_we, force_we;

  fdc_us_timer #(
    .CLK_PER_US(CLK_PER_US),
    .MAX_COUNT (MAX_US)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tmr_clear),
    .us_cnt(us_cnt)
  );

  // command decode: exact shapes only
  always_comb begin
    dec_op = OP_RESTORE;
    dec_ok = (cmd_data[3:2] == 2'b00);
    case (cmd_data[7:4])
      CODE_RESTORE:  dec_op = OP_RESTORE;
      CODE_SEEK:     dec_op = OP_SEEK;
      CODE_STEP:     dec_op = OP_STEP;
      CODE_STEP_IN:  dec_op = OP_STEP_IN;
      CODE_STEP_OUT: dec_op = OP_STEP_OUT;
      default:       dec_ok = 1'b0;
    endcase
  end

  assign head_we  = cmd_we && dec_ok && (state_q == ST_IDLE);
  assign force_we = cmd_we && (cmd_data == CODE_FORCE);
  assign gap_us   = UW'(rate_ms(rate_q) * US_PER_MS);

  // next-state logic
  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    rate_d    = rate_q;
    track_d   = track_q;
    dirc_d    = dirc_q;
    cnt_d     = cnt_q;
    abort_d   = abort_q;
    err_d     = err_q;
    tmr_clear = 1'b0;
    capture_o = 1'b0;
    fin       = 1'b0;
    issue     = 1'b0;
    issue_dir = dirc_q;

    if (force_we && state_q != ST_IDLE) abort_d = 1'b1;

    case (state_q)
      ST_IDLE: begin
        if (head_we) begin
          op_d    = dec_op;
          rate_d  = cmd_data[1:0];
          cnt_d   = '0;
          err_d   = 1'b0;
          abort_d = 1'b0;
          state_d = ST_DECIDE;
        end else if (force_we) begin
          capture_o = 1'b1;
        end
      end
      ST_DECIDE: begin
        if (abort_q) begin
          fin = 1'b1;
        end else begin
          case (op_q)
            OP_RESTORE: begin
              if (trk0_s) begin
                track_d = '0;
                fin     = 1'b1;
              end else if (cnt_q == CW'(RESTORE_LIMIT)) begin
                err_d = 1'b1;
                fin   = 1'b1;
              end else begin
                issue     = 1'b1;
                issue_dir = 1'b0;
              end
            end
            OP_SEEK: begin
              if (track_q == seek_target) begin
                fin = 1'b1;
              end else begin
                issue     = 1'b1;
                issue_dir = (seek_target > track_q);
              end
            end
            OP_STEP_IN: begin
              fin       = (cnt_q != '0);
              issue     = (cnt_q == '0);
              issue_dir = 1'b1;
            end
            OP_STEP_OUT: begin
              fin       = (cnt_q != '0);
              issue     = (cnt_q == '0);
              issue_dir = 1'b0;
            end
            default: begin
              fin   = (cnt_q != '0);
              issue = (cnt_q == '0);
            end
          endcase
        end
      end
      ST_PULSE: begin
        if (us_cnt >= UW'(PULSE_US)) state_d = ST_WAIT;
      end
      default: begin
        if (abort_q) fin = 1'b1;
        else if (us_cnt >= gap_us) state_d = ST_DECIDE;
      end
    endcase

    if (issue) begin
      state_d   = ST_PULSE;
      tmr_clear = 1'b1;
      dirc_d    = issue_dir;
      track_d   = issue_dir ? track_q + TRK_W'(1) : track_q - TRK_W'(1);
      cnt_d     = cnt_q + CW'(1);
    end
    if (fin) begin
      state_d   = ST_IDLE;
      capture_o = 1'b1;
      abort_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_RESTORE;
      rate_q  <= 2'd0;
      track_q <= '0;
      dirc_q  <= 1'b0;
      cnt_q   <= '0;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      rate_q  <= rate_d;
      track_q <= track_d;
      dirc_q  <= dirc_d;
      cnt_q   <= cnt_d;
      abort_q <= abort_d;
      err_q   <= err_d;
    end
  end

  assign step_o  = (state_q == ST_PULSE) && (us_cnt < UW'(PULSE_US));
  assign dirc_o  = dirc_q;
  assign track_o = track_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign err_o   = err_q;

  // R4: every new pulse moves the track register one place in its direction
  p_step_moves_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_o) |-> ((dirc_o && track_q == $past(track_q) + TRK_W'(1)) ||
                       (!dirc_o && track_q == $past(track_q) - TRK_W'(1))));

  // R4: direction line is steady while the pulse is high
  p_dir_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && $past(step_o)) |-> $stable(dirc_o));

  // R2: the pulse drops only once the second microsecond has elapsed
  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step_o) |-> ($past(us_cnt) == UW'(PULSE_US - 1)));

  // R6: the restore failure flag rises only after the full pulse budget
  p_restore_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(cnt_q) == CW'(RESTORE_LIMIT)));

  // R9: a command never ends while a pulse is high
  p_abort_no_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !$past(step_o));

endmodule

// File: rtl/fdc_head_stepper.sv
module fdc_head_stepper #(
  parameter int CLK_PER_US    = 125,
  parameter int US_PER_MS     = 1000,
  parameter int PRECOMP_ABOVE = 43,
  parameter int RESTORE_LIMIT = 255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  input  logic       data_we,
  input  logic [7:0] data_in,
  input  logic       drv_ready,
  input  logic       drv_trk0,
  input  logic       drv_index,
  input  logic       drv_wprot,
  output logic       step_o,
  output logic       dirc_o,
  output logic [7:0] track_o,
  output logic [7:0] status_o,
  output logic       busy_o,
  output logic       precomp_en_o
);

  localparam int TRK_W = 8;
  localparam int NSTAT = 4;

  logic [NSTAT-1:0] drv_s;      // {ready, wprot, trk0, index}
  logic [NSTAT-1:0] snap_q, snap_d;
  logic [TRK_W-1:0] target_q, target_d;
  logic             capture, err;

  fdc_sync2 #(.W(NSTAT)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({drv_ready, drv_wprot, drv_trk0, drv_index}),
    .sync_o (drv_s)
  );

  fdc_step_ctrl #(
    .CLK_PER_US   (CLK_PER_US),
    .US_PER_MS    (US_PER_MS),
    .RESTORE_LIMIT(RESTORE_LIMIT),
    .TRK_W        (TRK_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_data   (cmd_data),
    .seek_target(target_q),
    .trk0_s     (drv_s[1]),
    .step_o     (step_o),
    .dirc_o     (dirc_o),
    .track_o    (track_o),
    .busy_o     (busy_o),
    .err_o      (err),
    .capture_o  (capture)
  );

  always_comb begin
    snap_d   = capture ? drv_s : snap_q;
    target_d = data_we ? data_in : target_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q   <= '0;
      target_q <= '0;
    end else begin
      snap_q   <= snap_d;
      target_q <= target_d;
    end
  end

  assign status_o     = {2'b00, snap_q[3], snap_q[2], err, snap_q[1], snap_q[0], busy_o};
  assign precomp_en_o = (track_o > TRK_W'(PRECOMP_ABOVE));

  // R10: the status snapshot changes only on a capture event
  p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(snap_q));

endmodule

// File: tb/tb_fdc_head_stepper.sv
module tb_fdc_head_stepper;

  localparam int CPU = 2;
  localparam int UPM = 2;
  localparam int PW  = 2 * CPU;

  logic       clk, rst_n, cmd_we, data_we;
  logic [7:0] cmd_data, data_in;
  logic       drv_ready, drv_trk0, drv_index, drv_wprot;
  logic       step_o, dirc_o, busy_o, precomp_en_o;
  logic [7:0] track_o, status_o;

  fdc_head_stepper #(.CLK_PER_US(CPU), .US_PER_MS(UPM)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .data_we(data_we), .data_in(data_in), .drv_ready(drv_ready),
    .drv_trk0(drv_trk0), .drv_index(drv_index), .drv_wprot(drv_wprot),
    .step_o(step_o), .dirc_o(dirc_o), .track_o(track_o), .status_o(status_o),
    .busy_o(busy_o), .precomp_en_o(precomp_en_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed { logic [7:0] trk; logic dir; } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  int last_rise = -1, rise_cyc = 0, cur_gap = 0;
  logic prev_step = 1'b0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gap_cycles(input logic [1:0] code);
    int ms;
    case (code)
      2'd0: ms = 6;
      2'd1: ms = 12;
      2'd2: ms = 20;
      default: ms = 30;
    endcase
    return ms * UPM * CPU;
  endfunction

  // monitor: pops the scoreboard on each rising step pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (step_o && !prev_step) begin
        exp_t e;
        pulses++;
        if (q.size() == 0) begin
          check(0, "R1", "unexpected step pulse, track", int'(track_o), -1);
        end else begin
          e = q.pop_front();
          check(track_o == e.trk, "R4", "track after pulse", int'(track_o), int'(e.trk));
          check(dirc_o == e.dir, "R4", "direction of pulse", int'(dirc_o), int'(e.dir));
        end
        if (last_rise >= 0)
          check((cyc - last_rise) >= cur_gap && (cyc - last_rise) <= cur_gap + 2,
                "R3", "pulse spacing", cyc - last_rise, cur_gap);
        last_rise = cyc;
        rise_cyc  = cyc;
      end
      if (!step_o && prev_step)
        check((cyc - rise_cyc) == PW, "R2", "pulse width", cyc - rise_cyc, PW);
      prev_step = step_o;
    end
  end

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk);
    cmd_data = c;
    cmd_we   = 1'b1;
    @(negedge clk);
    cmd_we   = 1'b0;
  endtask

  task automatic start_cmd(input logic [7:0] c);
    last_rise = -1;
    cur_gap   = gap_cycles(c[1:0]);
    send_cmd(c);
  endtask

  task automatic set_target(input logic [7:0] v);
    @(negedge clk);
    data_in = v;
    data_we = 1'b1;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic push_run(input int from_t, input int to_t, input logic dir);
    exp_t e;
    if (dir) for (int t = from_t; t <= to_t; t++) begin e.trk = 8'(t); e.dir = 1'b1; q.push_back(e); end
    else     for (int t = from_t; t >= to_t; t--) begin e.trk = 8'(t); e.dir = 1'b0; q.push_back(e); end
  endtask

  task automatic wait_idle(input string req);
    repeat (2) @(negedge clk);
    while (busy_o) @(negedge clk);
    check(q.size() == 0, req, "pulses still expected", q.size(), 0);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; cmd_we = 1'b0; data_we = 1'b0; cmd_data = 8'h00; data_in = 8'h00;
    drv_ready = 1'b1; drv_trk0 = 1'b0; drv_index = 1'b0; drv_wprot = 1'b0;
    repeat (4) @(negedge clk);
    check(step_o == 0 && busy_o == 0 && dirc_o == 0 && precomp_en_o == 0, "R8",
          "reset outputs", {step_o, busy_o, dirc_o, precomp_en_o}, 0);
    check(track_o == 0, "R8", "reset track", track_o, 0);
    check(status_o == 0, "R8", "reset status", status_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4: single-pulse commands in both directions
    push_run(1, 1, 1'b1); start_cmd(8'h40);
    @(negedge clk);
    check(busy_o == 1 && status_o[0] == 1, "R8", "busy during command", busy_o, 1);
    wait_idle("R4");
    check(status_o == 8'h20, "R10", "status after step-in", status_o, 8'h20);
    push_run(2, 2, 1'b1); start_cmd(8'h41); wait_idle("R4");
    push_run(1, 1, 1'b0); start_cmd(8'h60); wait_idle("R4");
    push_run(0, 0, 1'b0); start_cmd(8'h20); wait_idle("R4");
    check(track_o == 0 && dirc_o == 0, "R4", "step keeps outward dir", track_o, 0);
    push_run(1, 1, 1'b1); start_cmd(8'h40); wait_idle("R4");
    push_run(2, 2, 1'b1); start_cmd(8'h20); wait_idle("R4");
    check(track_o == 2 && dirc_o == 1, "R4", "step keeps inward dir", track_o, 2);

    // R7/R3: seeks at rate codes 3 and 2
    set_target(8'd6);  push_run(3, 6, 1'b1); start_cmd(8'h13); wait_idle("R7");
    check(track_o == 6, "R7", "seek to 6", track_o, 6);
    set_target(8'd9);  push_run(7, 9, 1'b1); start_cmd(8'h12); wait_idle("R7");

    // R1: head command written while busy is ignored; R5 boundary
    set_target(8'd43); push_run(10, 43, 1'b1); start_cmd(8'h11);
    wait (pulses == 16);
    send_cmd(8'h40);
    wait_idle("R1");
    check(track_o == 43, "R1", "track after ignored step-in", track_o, 43);
    check(precomp_en_o == 0, "R5", "precomp at track 43", precomp_en_o, 0);
    push_run(44, 44, 1'b1); start_cmd(8'h40); wait_idle("R4");
    check(precomp_en_o == 1, "R5", "precomp at track 44", precomp_en_o, 1);

    // R7: seek onto current track issues nothing
    set_target(8'd44); start_cmd(8'h10); wait_idle("R7");
    check(track_o == 44, "R7", "seek equal track", track_o, 44);
    set_target(8'd40); push_run(43, 40, 1'b0); start_cmd(8'h10); wait_idle("R7");
    check(track_o == 40 && precomp_en_o == 0, "R5", "precomp off at 40", precomp_en_o, 0);

    // R6: restore reaching track zero after five pulses
    base = pulses;
    push_run(39, 35, 1'b0); start_cmd(8'h00);
    wait (pulses == base + 5);
    @(negedge clk); drv_trk0 = 1'b1;
    wait_idle("R6");
    check(track_o == 0, "R6", "track cleared by restore", track_o, 0);
    check(status_o == 8'h24, "R10", "status after restore", status_o, 8'h24);

    // R6: restore that never sees track zero
    drv_trk0 = 1'b0;
    repeat (4) @(negedge clk);
    push_run(255, 1, 1'b0); start_cmd(8'h00); wait_idle("R6");
    check(track_o == 1, "R6", "track after failed restore", track_o, 1);
    check(status_o == 8'h28, "R6", "error bit set", status_o, 8'h28);

    // R9: force-interrupt in the middle of a pulse
    set_target(8'd100); base = pulses;
    push_run(2, 4, 1'b1); start_cmd(8'h10);
    wait (pulses == base + 3);
    send_cmd(8'hD0);
    wait_idle("R9");
    repeat (40) @(negedge clk);
    check(pulses == base + 3, "R9", "pulse count after abort", pulses - base, 3);
    check(track_o == 4, "R9", "track after abort", track_o, 4);
    check(status_o == 8'h20, "R6", "error bit cleared by new command", status_o, 8'h20);

    // R1: malformed and unknown codes have no effect
    send_cmd(8'h44); send_cmd(8'h30); send_cmd(8'hD1);
    repeat (3) @(negedge clk);
    check(busy_o == 0 && track_o == 4, "R1", "undefined codes ignored", busy_o, 0);

    // R10: status holds while idle, then force-interrupt refreshes it
    drv_ready = 1'b0; drv_wprot = 1'b1; drv_index = 1'b1;
    repeat (5) @(negedge clk);
    check(status_o == 8'h20, "R10", "status held while idle", status_o, 8'h20);
    send_cmd(8'hD0);
    @(negedge clk);
    check(status_o == 8'h12, "R10", "status after idle force", status_o, 8'h12);
    check(busy_o == 0, "R9", "idle force leaves idle", busy_o, 0);

    summary();
    $finish;
  end

endmodule